// File: doc/BRIEF.md
# Dual-bank IN endpoint buffer controller

This block holds outgoing packets for one USB device IN endpoint in two packet banks that alternate. Software pushes packet bytes one word per write into the bank that currently accepts data. It then commits that bank to the USB side, in one of two ways. It can issue a commit command. Or, with automatic validation switched on, the hardware commits the bank in the same cycle that the bank's byte count reaches the configured packet limit.

The USB side serves committed banks oldest first. A request starts a read-out of the oldest committed bank, and read strobes step through its bytes. An acknowledge frees the bank. A missing acknowledge rewinds the bank so the same packet can be sent again. A request that finds nothing committed is answered with a NAK pulse.

A packet-ready flag is set while neither bank can take data. An interrupt, which can be enabled and disabled by command, tells software that a bank is free.

Top module: `inep_dual_bank`

## Requirements
- R1: After reset both banks are empty and pkt_rdy, irq, usb_active and usb_nak are all 0.
- R2: Each accepted cpu_wr stores cpu_wdata at the next byte position of the write bank. A write is ignored when the write bank is not empty or already holds the packet limit. The limit is cfg_max_pkt, except that 0 or a value above PKT_DEPTH means PKT_DEPTH.
- R3: cpu_commit on an empty write bank marks it full with its current byte count (zero allowed), and later writes go to the other bank; usb_len reports that count during read-out.
- R4: With cfg_auto=1, the write that brings the write bank's count to the limit also commits it; a shorter packet still needs cpu_commit.
- R5: pkt_rdy is 1 exactly when both banks are committed or being read out.
- R6: irq equals the enable bit AND NOT pkt_rdy; irq_en_set sets the enable, irq_en_clr clears it, clear wins when both are given, and the enable is 0 after reset.
- R7: usb_req while no read-out is active and a committed bank exists makes usb_active 1 from the next cycle on, serving banks in commit order; usb_req during a read-out is ignored.
- R8: During read-out usb_data shows the current byte, starting with the first byte written; usb_rd moves to the next byte and stops at the packet length.
- R9: usb_ack during read-out frees the bank (usb_active drops next cycle). usb_retry without usb_ack returns the bank to committed with its read position rewound to the first byte. Acknowledge wins over retry.
- R10: usb_req while no read-out is active and no bank is committed raises usb_nak for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_auto | input | 1 | Automatic commit on reaching the limit |
| cfg_max_pkt | input | CNT_W (7) | Packet byte limit (0 = PKT_DEPTH) |
| cpu_wr | input | 1 | Write one word into the write bank |
| cpu_wdata | input | DATA_W (8) | Write data |
| cpu_commit | input | 1 | Commit the write bank |
| irq_en_set | input | 1 | Enable the interrupt |
| irq_en_clr | input | 1 | Disable the interrupt |
| pkt_rdy | output | 1 | No bank free for writing |
| irq | output | 1 | Bank free and interrupt enabled |
| usb_req | input | 1 | Host asks for a packet |
| usb_rd | input | 1 | Step to next byte |
| usb_ack | input | 1 | Host acknowledged the packet |
| usb_retry | input | 1 | No acknowledge, resend later |
| usb_active | output | 1 | A bank is being read out |
| usb_nak | output | 1 | Previous request found no data |
| usb_len | output | CNT_W (7) | Byte count of the bank being read |
| usb_data | output | DATA_W (8) | Current byte of the bank being read |

## Verification
A software commit and a USB-side event can land in the same cycle. When both banks are empty, a commit that coincides with usb_req must still produce a NAK, because the request sees the state before the commit. A commit of the second bank that coincides with the acknowledge of the first must leave exactly one committed bank and keep pkt_rdy clear. The bench forces both cases with directed steps and then runs thousands of cycles of random traffic across both sides. A queue-based model judges every cycle, and it applies each cycle's updates against the state from before that cycle.

// File: rtl/inep_pkg.sv
`timescale 1ns/1ps
package inep_pkg;
   localparam int NBANK = 2;
   typedef enum logic [1:0] {
      BK_EMPTY = 2'd0,
      BK_DRAIN = 2'd1,
      BK_FULL  = 2'd2
   } bank_st_e;
endpackage

// File: rtl/inep_bank.sv
`timescale 1ns/1ps
module inep_bank
   import inep_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PKT_DEPTH = 64,
   localparam int AW       = $clog2(PKT_DEPTH),
   localparam int CNT_W    = $clog2(PKT_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit,
   input  logic              drain_start,
   input  logic              rd_adv,
   input  logic              rel,
   input  logic              resend,
   output bank_st_e          state,
   output logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  rd_ptr,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(PKT_DEPTH);

   logic [DATA_W-1:0] mem [PKT_DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[count[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= BK_EMPTY;
         count  <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_en) count <= count + 1'b1;
         case (state)
            BK_EMPTY: if (commit) state <= BK_FULL;
            BK_FULL: begin
               if (drain_start) begin
                  state  <= BK_DRAIN;
                  rd_ptr <= '0;
               end
            end
            BK_DRAIN: begin
               if (rel) begin
                  state  <= BK_EMPTY;
                  count  <= '0;
                  rd_ptr <= '0;
               end else if (resend) begin
                  state  <= BK_FULL;
                  rd_ptr <= '0;
               end else if (rd_adv && (rd_ptr < count)) begin
                  rd_ptr <= rd_ptr + 1'b1;
               end
            end
            default: state <= BK_EMPTY;
         endcase
      end
   end

   assign rd_data = mem[rd_ptr[AW-1:0]];

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= DEPTH_C);
   p_no_write_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state != BK_EMPTY) |-> !wr_en);
   p_commit_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BK_EMPTY && commit) |=> (state == BK_FULL));
   p_rd_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ptr <= count);
   p_rel_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BK_DRAIN && rel) |=> (state == BK_EMPTY && count == '0));
   p_resend_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BK_DRAIN && resend && !rel) |=> (state == BK_FULL && rd_ptr == '0));
endmodule

// File: rtl/inep_wr_ctrl.sv
`timescale 1ns/1ps
module inep_wr_ctrl
   import inep_pkg::*;
#(
   parameter int PKT_DEPTH = 64,
   parameter bit AUTO_EN   = 1'b1,
   localparam int CNT_W    = $clog2(PKT_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bank_st_e          bank_st [NBANK],
   input  logic [CNT_W-1:0]  bank_cnt [NBANK],
   input  logic              cpu_wr,
   input  logic              cpu_commit,
   input  logic              cfg_auto,
   input  logic [CNT_W-1:0]  cfg_max,
   input  logic              irq_set,
   input  logic              irq_clr,
   output logic [NBANK-1:0]  bank_wr,
   output logic [NBANK-1:0]  bank_commit,
   output logic              pkt_rdy,
   output logic              irq
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(PKT_DEPTH);

   logic             wb;
   logic             irq_en;
   bank_st_e         wst;
   logic [CNT_W-1:0] wcnt;
   logic [CNT_W-1:0] lim;
   logic             can_w;
   logic             wr_ok;
   logic             auto_hit;
   logic             commit_ok;

   assign wst   = bank_st[wb];
   assign wcnt  = bank_cnt[wb];
   assign lim   = (cfg_max == '0 || cfg_max > DEPTH_C) ? DEPTH_C : cfg_max;
   assign can_w = (wst == BK_EMPTY);
   assign wr_ok = cpu_wr && can_w && (wcnt < lim);

   generate
      if (AUTO_EN) begin : g_auto
         assign auto_hit = cfg_auto && wr_ok && ((wcnt + 1'b1) == lim);
      end else begin : g_manual
         assign auto_hit = 1'b0;
      end
   endgenerate

   assign commit_ok = can_w && (cpu_commit || auto_hit);

   always_comb begin
      for (int i = 0; i < NBANK; i++) begin
         bank_wr[i]     = wr_ok && (wb == 1'(i));
         bank_commit[i] = commit_ok && (wb == 1'(i));
      end
   end

   assign pkt_rdy = !can_w;
   assign irq     = irq_en && can_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb     <= 1'b0;
         irq_en <= 1'b0;
      end else begin
         wb <= wb ^ commit_ok;
         if (irq_clr)      irq_en <= 1'b0;
         else if (irq_set) irq_en <= 1'b1;
      end
   end

   p_pkt_rdy_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_rdy |-> (bank_st[0] != BK_EMPTY && bank_st[1] != BK_EMPTY));
   p_free_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_st[0] == BK_EMPTY || bank_st[1] == BK_EMPTY) |-> !pkt_rdy);
   p_irq_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |=> !irq);
endmodule

// File: rtl/inep_rd_ctrl.sv
`timescale 1ns/1ps
module inep_rd_ctrl
   import inep_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PKT_DEPTH = 64,
   localparam int CNT_W    = $clog2(PKT_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bank_st_e          bank_st [NBANK],
   input  logic [CNT_W-1:0]  bank_cnt [NBANK],
   input  logic [DATA_W-1:0] bank_rdata [NBANK],
   input  logic              usb_req,
   input  logic              usb_rd,
   input  logic              usb_ack,
   input  logic              usb_retry,
   output logic [NBANK-1:0]  bank_start,
   output logic [NBANK-1:0]  bank_adv,
   output logic [NBANK-1:0]  bank_rel,
   output logic [NBANK-1:0]  bank_resend,
   output logic              usb_active,
   output logic              usb_nak,
   output logic [CNT_W-1:0]  usb_len,
   output logic [DATA_W-1:0] usb_data
);
   logic     rb;
   bank_st_e rst;
   logic     start_ok;
   logic     nak_nxt;
   logic     rel_ok;

   assign rst        = bank_st[rb];
   assign usb_active = (rst == BK_DRAIN);
   assign start_ok   = usb_req && (rst == BK_FULL);
   assign nak_nxt    = usb_req && (rst == BK_EMPTY);
   assign rel_ok     = usb_ack && usb_active;
   assign usb_len    = bank_cnt[rb];
   assign usb_data   = bank_rdata[rb];

   always_comb begin
      for (int i = 0; i < NBANK; i++) begin
         bank_start[i]  = start_ok && (rb == 1'(i));
         bank_adv[i]    = usb_rd && usb_active && (rb == 1'(i));
         bank_rel[i]    = rel_ok && (rb == 1'(i));
         bank_resend[i] = usb_retry && !usb_ack && usb_active && (rb == 1'(i));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rb      <= 1'b0;
         usb_nak <= 1'b0;
      end else begin
         rb      <= rb ^ rel_ok;
         usb_nak <= nak_nxt;
      end
   end

   p_nak_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      usb_nak |-> !usb_active);
   p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (usb_req && bank_st[rb] == BK_FULL) |=> usb_active);
   p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (usb_ack && usb_active) |=> !usb_active);
endmodule

// File: rtl/inep_dual_bank.sv
`timescale 1ns/1ps
module inep_dual_bank
   import inep_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PKT_DEPTH = 64,
   parameter bit AUTO_EN   = 1'b1,
   localparam int CNT_W    = $clog2(PKT_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_auto,
   input  logic [CNT_W-1:0]  cfg_max_pkt,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_commit,
   input  logic              irq_en_set,
   input  logic              irq_en_clr,
   output logic              pkt_rdy,
   output logic              irq,
   input  logic              usb_req,
   input  logic              usb_rd,
   input  logic              usb_ack,
   input  logic              usb_retry,
   output logic              usb_active,
   output logic              usb_nak,
   output logic [CNT_W-1:0]  usb_len,
   output logic [DATA_W-1:0] usb_data
);
   generate
      if (PKT_DEPTH < 2 || (PKT_DEPTH & (PKT_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("PKT_DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
   endgenerate

   bank_st_e          bk_st   [NBANK];
   logic [CNT_W-1:0]  bk_cnt  [NBANK];
   logic [CNT_W-1:0]  bk_rptr [NBANK];
   logic [DATA_W-1:0] bk_rdat [NBANK];
   logic [NBANK-1:0]  bk_wr, bk_commit, bk_start, bk_adv, bk_rel, bk_resend;

   genvar gi;
   generate
      for (gi = 0; gi < NBANK; gi++) begin : g_bank
         inep_bank #(
            .DATA_W    (DATA_W),
            .PKT_DEPTH (PKT_DEPTH)
         ) i_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (bk_wr[gi]),
            .wr_data     (cpu_wdata),
            .commit      (bk_commit[gi]),
            .drain_start (bk_start[gi]),
            .rd_adv      (bk_adv[gi]),
            .rel         (bk_rel[gi]),
            .resend      (bk_resend[gi]),
            .state       (bk_st[gi]),
            .count       (bk_cnt[gi]),
            .rd_ptr      (bk_rptr[gi]),
            .rd_data     (bk_rdat[gi])
         );
      end
   endgenerate

   inep_wr_ctrl #(
      .PKT_DEPTH (PKT_DEPTH),
      .AUTO_EN   (AUTO_EN)
   ) i_wr_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bank_st     (bk_st),
      .bank_cnt    (bk_cnt),
      .cpu_wr      (cpu_wr),
      .cpu_commit  (cpu_commit),
      .cfg_auto    (cfg_auto),
      .cfg_max     (cfg_max_pkt),
      .irq_set     (irq_en_set),
      .irq_clr     (irq_en_clr),
      .bank_wr     (bk_wr),
      .bank_commit (bk_commit),
      .pkt_rdy     (pkt_rdy),
      .irq         (irq)
   );

   inep_rd_ctrl #(
      .DATA_W    (DATA_W),
      .PKT_DEPTH (PKT_DEPTH)
   ) i_rd_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bank_st     (bk_st),
      .bank_cnt    (bk_cnt),
      .bank_rdata  (bk_rdat),
      .usb_req     (usb_req),
      .usb_rd      (usb_rd),
      .usb_ack     (usb_ack),
      .usb_retry   (usb_retry),
      .bank_start  (bk_start),
      .bank_adv    (bk_adv),
      .bank_rel    (bk_rel),
      .bank_resend (bk_resend),
      .usb_active  (usb_active),
      .usb_nak     (usb_nak),
      .usb_len     (usb_len),
      .usb_data    (usb_data)
   );

   p_one_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bk_st[0] == BK_DRAIN && bk_st[1] == BK_DRAIN));
   p_rptr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(usb_active) |-> (usb_len >= bk_rptr[0] && usb_len >= bk_rptr[1]));
endmodule

// File: tb/test_inep_dual_bank.sv
`timescale 1ns/1ps
module test_inep_dual_bank;
   localparam int DW = 8;
   localparam int D  = 64;
   localparam int CW = $clog2(D + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_auto = 1'b0;
   logic [CW-1:0] cfg_max_pkt = CW'(4);
   logic          cpu_wr = 1'b0, cpu_commit = 1'b0, irq_en_set = 1'b0, irq_en_clr = 1'b0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          usb_req = 1'b0, usb_rd = 1'b0, usb_ack = 1'b0, usb_retry = 1'b0;
   logic          pkt_rdy, irq, usb_active, usb_nak;
   logic [CW-1:0] usb_len;
   logic [DW-1:0] usb_data;

   inep_dual_bank #(.DATA_W(DW), .PKT_DEPTH(D), .AUTO_EN(1'b1)) i_inep_dual_bank (
      .clk(clk), .rst_n(rst_n), .cfg_auto(cfg_auto), .cfg_max_pkt(cfg_max_pkt),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_commit(cpu_commit),
      .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr), .pkt_rdy(pkt_rdy), .irq(irq),
      .usb_req(usb_req), .usb_rd(usb_rd), .usb_ack(usb_ack), .usb_retry(usb_retry),
      .usb_active(usb_active), .usb_nak(usb_nak), .usb_len(usb_len), .usb_data(usb_data)
   );

   always #2.5 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;

   // behavioural reference
   logic [DW-1:0] m_pend[$];
   int            m_plen[$];
   logic [DW-1:0] m_fill[$];
   bit            m_act = 0;
   int            m_rd  = 0;
   bit            m_nak = 0;
   bit            m_ien = 0;

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_step();
      int lim  = (cfg_max_pkt == 0 || cfg_max_pkt > D) ? D : int'(cfg_max_pkt);
      bit canw = m_plen.size() < 2;
      bit wok  = cpu_wr && canw && (m_fill.size() < lim);
      bit cok  = canw && (cpu_commit || (cfg_auto && wok && (m_fill.size() + 1 == lim)));
      bit st   = usb_req && !m_act && m_plen.size() > 0;
      bit nk   = usb_req && !m_act && m_plen.size() == 0;
      bit adv  = usb_rd && m_act && (m_rd < m_plen[0]);
      bit ak   = usb_ack && m_act;
      bit rt   = usb_retry && m_act && !usb_ack;
      if (wok) m_fill.push_back(cpu_wdata);
      if (ak) begin
         repeat (m_plen[0]) void'(m_pend.pop_front());
         void'(m_plen.pop_front());
         m_act = 0;
         m_rd  = 0;
      end else if (rt) begin
         m_act = 0;
         m_rd  = 0;
      end else if (adv) begin
         m_rd++;
      end
      if (cok) begin
         m_plen.push_back(m_fill.size());
         foreach (m_fill[k]) m_pend.push_back(m_fill[k]);
         m_fill.delete();
      end
      if (st) begin
         m_act = 1;
         m_rd  = 0;
      end
      m_nak = nk;
      if (irq_en_clr)      m_ien = 0;
      else if (irq_en_set) m_ien = 1;
   endtask

   task automatic compare();
      chk("R5", "pkt_rdy", 64'(pkt_rdy), 64'(m_plen.size() == 2));
      chk("R6", "irq", 64'(irq), 64'(m_ien && m_plen.size() != 2));
      chk("R7", "usb_active", 64'(usb_active), 64'(m_act));
      chk("R10", "usb_nak", 64'(usb_nak), 64'(m_nak));
      if (m_act) begin
         chk("R3", "usb_len", 64'(usb_len), 64'(m_plen[0]));
         if (m_rd < m_plen[0]) chk("R8", "usb_data", 64'(usb_data), 64'(m_pend[m_rd]));
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
      cpu_wr = 0; cpu_commit = 0; irq_en_set = 0; irq_en_clr = 0;
      usb_req = 0; usb_rd = 0; usb_ack = 0; usb_retry = 0;
   endtask

   task automatic wr(input logic [DW-1:0] b);
      cpu_wr = 1; cpu_wdata = b; tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "pkt_rdy in reset", 64'(pkt_rdy), 0);
      chk("R1", "irq in reset", 64'(irq), 0);
      chk("R1", "usb_active in reset", 64'(usb_active), 0);
      chk("R1", "usb_nak in reset", 64'(usb_nak), 0);
      rst_n = 1;

      irq_en_set = 1; tick();
      chk("R6", "irq after enable", 64'(irq), 1);

      // manual commits, second packet over-written past the limit
      wr(8'h11); wr(8'h12); wr(8'h13);
      cpu_commit = 1; tick();
      wr(8'h21); wr(8'h22); wr(8'h23); wr(8'h24); wr(8'h25);
      cpu_commit = 1; tick();
      chk("R5", "both full", 64'(pkt_rdy), 1);
      wr(8'h99);

      usb_req = 1; tick();
      chk("R7", "first bank served", 64'(usb_len), 3);
      usb_rd = 1; tick();
      usb_rd = 1; tick();
      usb_retry = 1; tick();
      chk("R9", "retry releases read-out", 64'(usb_active), 0);
      usb_req = 1; tick();
      chk("R9", "resent first byte", 64'(usb_data), 8'h11);
      repeat (4) begin usb_rd = 1; tick(); end
      usb_ack = 1; usb_retry = 1; tick();
      chk("R9", "ack wins", 64'(pkt_rdy), 0);
      usb_req = 1; tick();
      chk("R2", "length capped at limit", 64'(usb_len), 4);
      repeat (4) begin usb_rd = 1; tick(); end
      usb_ack = 1; tick();
      usb_req = 1; tick();
      chk("R10", "nak on empty", 64'(usb_nak), 1);
      tick();
      chk("R10", "nak one cycle", 64'(usb_nak), 0);

      // automatic commit
      cfg_auto = 1;
      wr(8'h31); wr(8'h32); wr(8'h33); wr(8'h34);
      usb_req = 1; tick();
      chk("R4", "auto committed", 64'(usb_len), 4);
      wr(8'h41); wr(8'h42);
      chk("R4", "short packet not committed", 64'(pkt_rdy), 0);
      cpu_commit = 1; usb_ack = 1; tick();
      chk("R5", "commit with ack", 64'(pkt_rdy), 0);
      usb_req = 1; tick();
      chk("R3", "short length", 64'(usb_len), 2);
      usb_ack = 1; tick();

      // commit together with request on an idle endpoint
      cpu_commit = 1; usb_req = 1; tick();
      chk("R10", "request sees pre-commit state", 64'(usb_nak), 1);
      usb_req = 1; tick();
      chk("R3", "zero-length packet", 64'(usb_len), 0);
      usb_ack = 1; tick();

      irq_en_set = 1; irq_en_clr = 1; tick();
      chk("R6", "clear wins", 64'(irq), 0);

      // limit 0 means full depth
      cfg_max_pkt = '0;
      for (int i = 0; i < D; i++) wr(DW'(i + 5));
      usb_req = 1; tick();
      chk("R4", "full-depth auto commit", 64'(usb_len), D);
      usb_ack = 1; tick();

      // random traffic
      for (int c = 0; c < 3000; c++) begin
         if (c % 200 == 0) begin
            cfg_auto    = 1'($urandom % 2);
            cfg_max_pkt = CW'($urandom % 7);
         end
         cpu_wr     = ($urandom % 3) == 0;
         cpu_wdata  = DW'($urandom);
         cpu_commit = ($urandom % 10) == 0;
         irq_en_set = ($urandom % 20) == 0;
         irq_en_clr = ($urandom % 25) == 0;
         usb_req    = ($urandom % 4) == 0;
         usb_rd     = ($urandom % 2) == 0;
         usb_ack    = ($urandom % 8) == 0;
         usb_retry  = ($urandom % 16) == 0;
         tick();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule